// File: doc/BRIEF.md
# Inertial Event Interrupt Generator

This block watches a stream of signed acceleration samples for three axes, one set of X, Y and Z values per sample strobe. Each axis is compared against a programmable 7-bit threshold. The resulting high and low events are masked by per-event enables and combined in one of four ways: any enabled event (OR), all enabled events (AND), a change of orientation, or a stable orientation. A combined condition must hold for a programmable number of consecutive samples before it raises the interrupt line.

Software programs the block through a small parallel register port with four byte-wide registers. It reads back a source register that shows the interrupt-active flag and the six masked event flags. An optional latch holds the interrupt and the source flags until the source register is read. With the latch off, they follow the most recent sample.

Register map (address on `reg_addr`): 0 = mode/enable, 1 = threshold, 2 = duration/latch, 3 = event source (read only). The mode/enable byte holds bit7 = AND select, bit6 = orientation select, and bits 5..0 = enables for Z-high, Z-low, Y-high, Y-low, X-high and X-low. The source byte uses the same positions for its event flags, with bit6 = interrupt active and bit7 = 0. The duration/latch byte holds bit7 = latch enable and bits 6..0 = minimum duration.

Top module: `inertial_irq_gen`

## Requirements
- R1: In OR/AND modes an axis is "high" when its magnitude exceeds the threshold and "low" when its magnitude is at or below it. The magnitude of -128 is taken as 127.
- R2: With bit7=0 and bit6=0 of register 0, the condition is true when any enabled event is present.
- R3: With bit7=1 and bit6=0, the condition is true when every enabled event is present. With no event enabled it is never true.
- R4: With bit6=1 the events become directional: "high" means value > +threshold and "low" means value < -threshold. With bit7=1, the condition is true when exactly one enabled directional event is present (stable orientation).
- R5: With bit6=1 and bit7=0, the condition is true on a sample whose set of enabled directional events differs from the set seen on the previous sample. That previous set is zero after reset.
- R6: The interrupt asserts on the (N+1)-th consecutive qualifying sample, where N is the duration field. A non-qualifying sample restarts the count.
- R7: With the latch enabled, a set interrupt holds, together with its source flags, until address 3 is read. If a read and a new sample fall in the same cycle, the new sample's result is loaded.
- R8: With the latch disabled, the interrupt and source flags are reloaded on every sample and a source read has no effect. Without a sample the interrupt never changes.
- R9: Registers 0 to 2 read back what was written. Bit7 of the threshold register and bit7 of the source register read 0. Writes to address 3 have no effect.
- R10: Reset clears every register and holds the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: a new sample set is present |
| smp_x | input | 8 | X sample, two's complement |
| smp_y | input | 8 | Y sample, two's complement |
| smp_z | input | 8 | Z sample, two's complement |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears the latch on address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| irq | output | 1 | Interrupt line |

## Verification
A read of the source register can arrive in the same cycle as a new sample, so the read-clear of the latch competes with the reload from that sample. The bench forces this collision with the latch on, once with a qualifying sample and once with a quiet one, and also throws it at random. A behavioural model gives the new sample priority. The data returned by the read must still show the pre-clear value, and the interrupt after the edge must match the fresh sample's result.

// File: rtl/iev_pkg.sv
`timescale 1ns/1ps
package iev_pkg;
    localparam int SMP_W_DEF = 8;
    localparam int N_AXES    = 3;

    localparam logic [1:0] A_CFG = 2'd0;
    localparam logic [1:0] A_THS = 2'd1;
    localparam logic [1:0] A_DUR = 2'd2;
    localparam logic [1:0] A_SRC = 2'd3;

    typedef struct packed {
        logic zh;
        logic zl;
        logic yh;
        logic yl;
        logic xh;
        logic xl;
    } ev_flags_t;

    typedef struct packed {
        logic      aoi;
        logic      six_d;
        ev_flags_t en;
    } cfg_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } axis_ev_t;

    typedef enum logic [1:0] {
        CMB_OR,
        CMB_AND,
        CMB_MOVE,
        CMB_POS
    } cmb_mode_e;

    function automatic cmb_mode_e mode_of(cfg_t c);
        case ({c.six_d, c.aoi})
            2'b00:   return CMB_OR;
            2'b01:   return CMB_AND;
            2'b10:   return CMB_MOVE;
            default: return CMB_POS;
        endcase
    endfunction

    function automatic logic at_most_one(ev_flags_t f);
        logic [5:0] v;
        v = f;
        return (v & (v - 6'd1)) == 6'd0;
    endfunction
endpackage

// File: rtl/iev_axis_eval.sv
`timescale 1ns/1ps
module iev_axis_eval
    import iev_pkg::*;
#(
    parameter int W = SMP_W_DEF
) (
    input  logic signed [W-1:0] smp,
    input  logic [W-2:0]        ths,
    input  logic                directional,
    output axis_ev_t            ev
);
    localparam logic [W-2:0] MAG_MAX = '1;
    localparam logic [W-1:0] ONE     = W'(1);

    logic         neg;
    logic [W-1:0] raw;
    logic [W-1:0] abs_v;
    logic [W-2:0] mag;
    logic         above;

    always_comb begin
        raw   = smp;
        neg   = raw[W-1];
        abs_v = neg ? (~raw + ONE) : raw;
        mag   = abs_v[W-1] ? MAG_MAX : abs_v[W-2:0];
        above = mag > ths;
        if (directional) begin
            ev.hi = above && !neg;
            ev.lo = above && neg;
        end else begin
            ev.hi = above;
            ev.lo = !above;
        end
    end
endmodule

// File: rtl/iev_combine.sv
`timescale 1ns/1ps
module iev_combine
    import iev_pkg::*;
(
    input  ev_flags_t raw,
    input  cfg_t      cfg,
    input  ev_flags_t prev,
    output ev_flags_t masked,
    output logic      cond
);
    always_comb begin
        masked = ev_flags_t'(raw & cfg.en);
        case (mode_of(cfg))
            CMB_OR:   cond = |masked;
            CMB_AND:  cond = (cfg.en != '0) && (masked == cfg.en);
            CMB_MOVE: cond = masked != prev;
            default:  cond = (masked != '0) && at_most_one(masked);
        endcase
    end
endmodule

// File: rtl/iev_duration.sv
`timescale 1ns/1ps
module iev_duration #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          cond,
    input  logic [CW-1:0] limit,
    output logic          qual
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] run_cnt;

    assign qual = cond && (run_cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (tick) begin
            if (!cond)
                run_cnt <= '0;
            else if (run_cnt != CMAX)
                run_cnt <= run_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/inertial_irq_gen.sv
`timescale 1ns/1ps
module inertial_irq_gen
    import iev_pkg::*;
#(
    parameter int SMP_W = SMP_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_x,
    input  logic signed [SMP_W-1:0] smp_y,
    input  logic signed [SMP_W-1:0] smp_z,
    input  logic                    reg_we,
    input  logic                    reg_re,
    input  logic [1:0]              reg_addr,
    input  logic [SMP_W-1:0]        reg_wdata,
    output logic [SMP_W-1:0]        reg_rdata,
    output logic                    irq
);
    localparam int MAG_W = SMP_W - 1;

    cfg_t             cfg_q;
    logic [MAG_W-1:0] ths_q;
    logic [MAG_W-1:0] dur_q;
    logic             latch_q;
    ev_flags_t        prev_q;
    ev_flags_t        src_q;
    logic             ia_q;

    logic signed [SMP_W-1:0] smp_arr [N_AXES];
    axis_ev_t                ax_ev   [N_AXES];
    logic [2*N_AXES-1:0]     raw_bits;
    ev_flags_t               masked;
    logic                    cond;
    logic                    qual;
    logic                    rd_clr;
    logic                    hold;

    assign smp_arr[0] = smp_x;
    assign smp_arr[1] = smp_y;
    assign smp_arr[2] = smp_z;

    for (genvar i = 0; i < N_AXES; i++) begin : g_axis
        iev_axis_eval #(.W(SMP_W)) u_ax (
            .smp        (smp_arr[i]),
            .ths        (ths_q),
            .directional(cfg_q.six_d),
            .ev         (ax_ev[i])
        );
        assign raw_bits[2*i]   = ax_ev[i].lo;
        assign raw_bits[2*i+1] = ax_ev[i].hi;
    end

    iev_combine u_comb (
        .raw   (ev_flags_t'(raw_bits)),
        .cfg   (cfg_q),
        .prev  (prev_q),
        .masked(masked),
        .cond  (cond)
    );

    iev_duration #(.CW(MAG_W)) u_dur (
        .clk  (clk),
        .rst  (rst),
        .tick (smp_valid),
        .cond (cond),
        .limit(dur_q),
        .qual (qual)
    );

    assign rd_clr = reg_re && (reg_addr == A_SRC);
    assign hold   = latch_q && ia_q && !rd_clr;
    assign irq    = ia_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            ths_q   <= '0;
            dur_q   <= '0;
            latch_q <= 1'b0;
            prev_q  <= '0;
            src_q   <= '0;
            ia_q    <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    A_CFG: cfg_q <= cfg_t'(reg_wdata[7:0]);
                    A_THS: ths_q <= reg_wdata[MAG_W-1:0];
                    A_DUR: begin
                        latch_q <= reg_wdata[SMP_W-1];
                        dur_q   <= reg_wdata[MAG_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (smp_valid)
                prev_q <= masked;
            if (smp_valid && !hold) begin
                ia_q  <= qual;
                src_q <= masked;
            end else if (rd_clr && latch_q) begin
                ia_q  <= 1'b0;
                src_q <= '0;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_CFG:   reg_rdata = SMP_W'(cfg_q);
            A_THS:   reg_rdata = {1'b0, ths_q};
            A_DUR:   reg_rdata = {latch_q, dur_q};
            default: reg_rdata = SMP_W'({ia_q, src_q});
        endcase
    end
endmodule

// File: rtl/iev_checker.sv
`timescale 1ns/1ps
module iev_checker
    import iev_pkg::*;
#(
    parameter int SMP_W = SMP_W_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic             reg_re,
    input logic [1:0]       reg_addr,
    input logic [SMP_W-1:0] reg_rdata,
    input logic             latch_en,
    input logic             irq
);
    logic src_rd;
    assign src_rd = reg_re && (reg_addr == A_SRC);

    AST_RESET_IRQ_LOW: assert property (@(posedge clk) rst |=> !irq); // R10

    AST_IRQ_ONLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !src_rd) |=> $stable(irq)); // R8

    AST_READ_CLEARS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (latch_en && src_rd && !smp_valid) |=> !irq); // R7

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (latch_en && irq && !src_rd) |=> irq); // R7

    AST_THS_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_THS) |-> !reg_rdata[SMP_W-1]); // R9

    AST_SRC_IA_MATCHES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_SRC) |-> (reg_rdata[6] == irq && !reg_rdata[7])); // R7
endmodule

bind inertial_irq_gen iev_checker #(.SMP_W(SMP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_valid(smp_valid),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .latch_en (latch_q),
    .irq      (irq)
);

// File: tb/inertial_irq_gen_test.sv
`timescale 1ns/1ps
module inertial_irq_gen_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic       reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    inertial_irq_gen uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int m_cfg = 0, m_ths = 0, m_dur = 0, m_latch = 0;
    int m_prev = 0, m_src = 0, m_ia = 0, m_cnt = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0:       return m_cfg;
            1:       return m_ths;
            2:       return (m_latch << 7) | m_dur;
            default: return (m_ia << 6) | m_src;
        endcase
    endfunction

    function automatic int model_flags(input int x, input int y, input int z);
        int vals[3];
        int f, mag, hi, lo;
        bit six;
        vals[0] = x; vals[1] = y; vals[2] = z;
        six = ((m_cfg >> 6) & 1) == 1;
        f = 0;
        for (int i = 0; i < 3; i++) begin
            mag = (vals[i] < 0) ? -vals[i] : vals[i];
            if (mag > 127) mag = 127;
            if (six) begin
                hi = (vals[i] > 0 && mag > m_ths) ? 1 : 0;
                lo = (vals[i] < 0 && mag > m_ths) ? 1 : 0;
            end else begin
                hi = (mag > m_ths) ? 1 : 0;
                lo = 1 - hi;
            end
            f = f | (lo << (2 * i)) | (hi << (2 * i + 1));
        end
        return f;
    endfunction

    task automatic step(input bit v, input int x, input int y, input int z,
                        input bit we, input bit re, input int addr, input int wd,
                        input string tag);
        int en, msk, cond, qual, aoi, six, rdclr, hold;
        @(negedge clk);
        smp_valid = v; smp_x = 8'(x); smp_y = 8'(y); smp_z = 8'(z);
        reg_we = we; reg_re = re; reg_addr = 2'(addr); reg_wdata = 8'(wd);
        #1;
        if (re || !we) chk({tag, " rdata"}, 32'(reg_rdata), 32'(model_read(addr)));
        @(posedge clk);
        en  = m_cfg & 63;
        aoi = (m_cfg >> 7) & 1;
        six = (m_cfg >> 6) & 1;
        msk = model_flags(x, y, z) & en;
        if (six == 0 && aoi == 0)      cond = (msk != 0);
        else if (six == 0)             cond = (en != 0 && msk == en);
        else if (aoi == 0)             cond = (msk != m_prev);
        else                           cond = (msk != 0 && $countones(msk) == 1);
        qual  = (cond != 0 && m_cnt >= m_dur) ? 1 : 0;
        rdclr = (re && addr == 3) ? 1 : 0;
        hold  = (m_latch != 0 && m_ia != 0 && rdclr == 0) ? 1 : 0;
        if (v) begin
            m_cnt  = (cond != 0) ? ((m_cnt < 127) ? m_cnt + 1 : 127) : 0;
            m_prev = msk;
        end
        if (v && hold == 0) begin
            m_ia = qual; m_src = msk;
        end else if (rdclr != 0 && m_latch != 0) begin
            m_ia = 0; m_src = 0;
        end
        if (we) begin
            case (addr)
                0: m_cfg = wd & 255;
                1: m_ths = wd & 127;
                2: begin m_latch = (wd >> 7) & 1; m_dur = wd & 127; end
                default: ;
            endcase
        end
        #1;
        chk({tag, " irq"}, 32'(irq), 32'(m_ia));
        reg_we = 0; reg_re = 0; smp_valid = 0;
    endtask

    task automatic wr(input int a, input int d, input string tag);
        step(0, 0, 0, 0, 1, 0, a, d, tag);
    endtask
    task automatic rd(input int a, input string tag);
        step(0, 0, 0, 0, 0, 1, a, 0, tag);
    endtask
    task automatic smp(input int x, input int y, input int z, input string tag);
        step(1, x, y, z, 0, 0, 0, 0, tag);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R10 reset irq", 32'(irq), 32'd0);
        for (int a = 0; a < 4; a++) rd(a, "R10 reset regs");

        // R9 readback, top bit of threshold reads zero
        wr(1, 8'hA8, "R9 ths write");
        rd(1, "R9 ths readback");
        chk("R9 ths top bit", 32'(reg_rdata[7]), 32'd0);
        wr(0, 8'h02, "R9 cfg write");
        rd(0, "R9 cfg readback");

        // R1/R2 magnitude compare in OR mode (threshold 40, X-high)
        smp(50, 0, 0, "R2 or x high");
        chk("R2 or hard", 32'(irq), 32'd1);
        smp(30, 0, 0, "R1 below");
        smp(-50, 0, 0, "R1 negative magnitude");
        smp(40, 0, 0, "R1 equal not high");
        chk("R1 equal hard", 32'(irq), 32'd0);
        wr(0, 8'h01, "R2 x low");
        smp(40, 0, 0, "R1 equal is low");
        smp(0, 90, -90, "R2 or multi");
        wr(0, 8'h3F, "R2 all");
        smp(100, 100, 100, "R2 any");
        wr(1, 127, "R1 ths max");
        wr(0, 8'h02, "R1 cfg");
        smp(-128, 0, 0, "R1 min sample saturates");
        chk("R1 min hard", 32'(irq), 32'd0);
        wr(1, 40, "ths back");

        // R3 AND mode
        wr(0, 8'h8A, "R3 cfg");
        smp(50, 10, 0, "R3 one of two");
        smp(50, -60, 0, "R3 both");
        chk("R3 both hard", 32'(irq), 32'd1);
        wr(0, 8'h80, "R3 empty");
        smp(100, 100, 100, "R3 empty mask never");

        // R4 orientation position
        wr(0, 8'hFF, "R4 cfg");
        smp(60, 0, 0, "R4 x plus");
        chk("R4 hard", 32'(irq), 32'd1);
        smp(60, 60, 0, "R4 two axes");
        smp(-60, 0, 0, "R4 x minus");
        smp(0, 0, 0, "R4 flat");

        // R5 orientation movement
        wr(0, 8'h7F, "R5 cfg");
        smp(0, 0, 70, "R5 move in");
        smp(0, 0, 70, "R5 still");
        chk("R5 still hard", 32'(irq), 32'd0);
        smp(0, -70, 0, "R5 move again");
        smp(0, 0, 0, "R5 to none");

        // R6 duration
        wr(0, 8'h02, "R6 cfg");
        wr(2, 3, "R6 dur");
        smp(60, 0, 0, "R6 s1");
        smp(60, 0, 0, "R6 s2");
        smp(0, 0, 0, "R6 break");
        for (int k = 0; k < 3; k++) smp(60, 0, 0, "R6 run");
        chk("R6 not yet", 32'(irq), 32'd0);
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle gap");
        smp(60, 0, 0, "R6 fourth");
        chk("R6 fourth hard", 32'(irq), 32'd1);
        rd(3, "R8 read no effect");
        chk("R8 still set", 32'(irq), 32'd1);
        smp(0, 0, 0, "R8 follows");

        // R7 latch
        wr(2, 8'h80, "R7 latch");
        smp(60, 0, 0, "R7 set");
        smp(0, 0, 0, "R7 hold");
        chk("R7 hold hard", 32'(irq), 32'd1);
        wr(3, 8'h00, "R9 src write ignored");
        rd(3, "R7 read clears");
        chk("R7 cleared", 32'(irq), 32'd0);
        smp(60, 0, 0, "R7 set again");
        step(1, 60, 0, 0, 0, 1, 3, 0, "R7 read with qualifying sample");
        chk("R7 collision keeps", 32'(irq), 32'd1);
        step(1, 0, 0, 0, 0, 1, 3, 0, "R7 read with quiet sample");
        chk("R7 collision quiet", 32'(irq), 32'd0);

        // mixed random traffic against the model
        for (int k = 0; k < 400; k++) begin
            bit v, we, re;
            int a;
            v  = ($urandom % 3) != 0;
            we = ($urandom % 8) == 0;
            re = ($urandom % 5) == 0;
            a  = int'($urandom % 4);
            step(v, int'($signed(8'($urandom))), int'($signed(8'($urandom))),
                 int'($signed(8'($urandom))), we, re, a,
                 (a == 2) ? int'($urandom % 256) & 8'h87 : int'($urandom % 256),
                 "R1 R7 random");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule